// File: doc/BRIEF.md
# Chip-Select Decoder with Wait-State Acknowledge

This block turns bus addresses into one of up to eight chip-select outputs. Every channel holds a base tag, a mask with a valid flag, and a control word. Software programs them through a small register port. When an access starts, the block compares the upper address bits against every valid channel and selects the lowest-numbered channel that matches. It then holds that chip select until the access has finished.

Each data beat of an access ends in one of two ways. A channel with auto-acknowledge set counts a programmed number of wait states and then raises an internal transfer acknowledge. An external acknowledge ends the beat at once, whether or not the countdown has finished. A channel without auto-acknowledge waits for the external acknowledge only. Multi-beat accesses are allowed only when the channel enables bursts for that direction. Between beats the presented address steps by one 32-bit word.

Top module: `cs_decoder`

## Requirements
- R1: After reset every channel is invalid. All registers read 0, `cs_sel` and `busy` are 0, and an access to any address selects nothing.
- R2: Channel n keeps its base at byte offset 0x080+0x0C*n, its mask at 0x084+0x0C*n and its control at 0x08A+0x0C*n. The base reads back as bits [31:16] with the low half zero. The mask reads back as bits [31:16] plus the valid flag in bit 0. An unmapped offset reads 0.
- R3: In the control word, only these fields are stored: wait states in bits [13:10], auto-acknowledge in bit 8, burst-read enable in bit 4 and burst-write enable in bit 3. Every other bit, including the reserved bits [2:0], reads as 0.
- R4: A channel matches when its valid flag is set and `bus_addr[31:16]` equals its base in every bit that is clear in its mask. A channel whose valid flag is clear never asserts.
- R5: When several channels match, only the lowest-numbered one is selected. `cs_sel` never has more than one bit set.
- R6: A `bus_start` that hits a channel raises that `cs_sel` bit and `busy` in the next cycle. Both stay steady until the final beat terminates, and both clear in the following cycle.
- R7: With auto-acknowledge 1 and wait-state field W, `ta_int` is high in cycle W of each beat, counting from 0. This ends the beat after W+1 cycles.
- R8: With auto-acknowledge 0, `ta_int` never asserts, and a beat lasts until `ext_ack` is seen.
- R9: `ext_ack` high during a busy cycle ends the current beat in that cycle (`beat_end`), even when the countdown has not yet finished.
- R10: An access runs `bus_beats_m1`+1 beats when the channel's burst enable for its direction (write: bit 3, read: bit 4) is set, and one beat otherwise. `cs_addr` holds the start address and steps by 4 after each beat that is not the last.
- R11: `bus_start` is ignored while an access is in progress or when no channel matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_start | input | 1 | One-cycle access start pulse |
| bus_addr | input | 32 | Access address, sampled with bus_start |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_beats_m1 | input | 2 | Requested beats minus one |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_sel | output | 8 | Active-high chip selects |
| cs_addr | output | 32 | Current beat address |
| ta_int | output | 1 | Internal transfer acknowledge |
| beat_end | output | 1 | Current beat terminates this cycle |
| busy | output | 1 | Access in progress |

## Verification
A wrong wait-state counter appears at the ports as `ta_int` arriving in the wrong cycle. The total busy length of an access therefore differs from (W+1) times the number of beats, and the difference shows up on the first beat. A wrong beat counter or step shows up as a wrong final `cs_addr` or an access that runs too long or too short. A faulty priority or mask decode shows up in the first busy cycle as the wrong `cs_sel` bit, or as no bit at all.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int WS_W        = 4;
    localparam int CTL_WS_LSB  = 10;
    localparam int CTL_AA_BIT  = 8;
    localparam int CTL_BR_BIT  = 4;
    localparam int CTL_BW_BIT  = 3;

    typedef struct packed {
        logic [WS_W-1:0] ws;
        logic            aa;
        logic            br;
        logic            bw;
    } cs_ctl_t;
endpackage

// File: rtl/cs_regs.sv
module cs_regs
    import cs_pkg::*;
#(
    parameter int NUM_CS     = 8,
    parameter int ADDR_W     = 32,
    parameter int TAG_LSB    = 16,
    parameter int REG_AW     = 8,
    parameter int BLOCK_BASE = 'h080,
    parameter int STRIDE     = 'h00C,
    parameter int MASK_OFS   = 'h004,
    parameter int CTL_OFS    = 'h00A
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [ADDR_W-1:0]                 reg_wdata,
    output logic [ADDR_W-1:0]                 reg_rdata,
    output logic [NUM_CS-1:0][ADDR_W-TAG_LSB-1:0] base_o,
    output logic [NUM_CS-1:0][ADDR_W-TAG_LSB-1:0] mask_o,
    output logic [NUM_CS-1:0]                 valid_o,
    output cs_ctl_t [NUM_CS-1:0]              ctl_o
);
    localparam int TAG_W = ADDR_W - TAG_LSB;

    typedef struct packed {
        logic [NUM_CS-1:0][TAG_W-1:0] base;
        logic [NUM_CS-1:0][TAG_W-1:0] mask;
        logic [NUM_CS-1:0]            valid;
        cs_ctl_t [NUM_CS-1:0]         ctl;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        r_d       = r_q;
        reg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (reg_addr == REG_AW'(BLOCK_BASE + STRIDE * i)) begin
                reg_rdata = {r_q.base[i], {TAG_LSB{1'b0}}};
                if (reg_wr) r_d.base[i] = reg_wdata[ADDR_W-1:TAG_LSB];
            end
            if (reg_addr == REG_AW'(BLOCK_BASE + STRIDE * i + MASK_OFS)) begin
                reg_rdata    = {r_q.mask[i], {TAG_LSB{1'b0}}};
                reg_rdata[0] = r_q.valid[i];
                if (reg_wr) begin
                    r_d.mask[i]  = reg_wdata[ADDR_W-1:TAG_LSB];
                    r_d.valid[i] = reg_wdata[0];
                end
            end
            if (reg_addr == REG_AW'(BLOCK_BASE + STRIDE * i + CTL_OFS)) begin
                reg_rdata[CTL_WS_LSB +: WS_W] = r_q.ctl[i].ws;
                reg_rdata[CTL_AA_BIT]         = r_q.ctl[i].aa;
                reg_rdata[CTL_BR_BIT]         = r_q.ctl[i].br;
                reg_rdata[CTL_BW_BIT]         = r_q.ctl[i].bw;
                if (reg_wr) begin
                    r_d.ctl[i].ws = reg_wdata[CTL_WS_LSB +: WS_W];
                    r_d.ctl[i].aa = reg_wdata[CTL_AA_BIT];
                    r_d.ctl[i].br = reg_wdata[CTL_BR_BIT];
                    r_d.ctl[i].bw = reg_wdata[CTL_BW_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_o  = r_q.base;
    assign mask_o  = r_q.mask;
    assign valid_o = r_q.valid;
    assign ctl_o   = r_q.ctl;
endmodule

// File: rtl/cs_match.sv
module cs_match #(
    parameter int NUM_CS = 8,
    parameter int TAG_W  = 16
) (
    input  logic [TAG_W-1:0]              addr_tag,
    input  logic [NUM_CS-1:0][TAG_W-1:0]  base,
    input  logic [NUM_CS-1:0][TAG_W-1:0]  mask,
    input  logic [NUM_CS-1:0]             valid,
    output logic [NUM_CS-1:0]             hit_sel,
    output logic                          hit_any
);
    logic [NUM_CS-1:0] raw;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign raw[g] = valid[g] && ((addr_tag & ~mask[g]) == (base[g] & ~mask[g]));
    end

    // isolate the lowest set bit: lowest channel number has priority
    assign hit_sel = raw & (~raw + 1'b1);
    assign hit_any = |raw;
endmodule

// File: rtl/cs_term.sv
module cs_term
    import cs_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 2,
    parameter int STEP   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_CS-1:0]    hit_sel,
    input  logic                 hit_any,
    input  cs_ctl_t [NUM_CS-1:0] ctl,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_write,
    input  logic [BEAT_W-1:0]    beats_m1,
    input  logic                 ext_ack,
    output logic [NUM_CS-1:0]    cs_sel,
    output logic [ADDR_W-1:0]    cs_addr,
    output logic                 ta_int,
    output logic                 beat_end,
    output logic                 busy
);
    typedef struct packed {
        logic              busy;
        logic [NUM_CS-1:0] sel;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] left;
        logic [WS_W-1:0]   cnt;
        logic [WS_W-1:0]   ws;
        logic              aa;
    } st_t;

    st_t     s_d, s_q;
    cs_ctl_t pick;
    logic    burst_ok;

    always_comb begin
        s_d  = s_q;
        pick = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit_sel[i]) pick = ctl[i];
        end
        burst_ok = bus_write ? pick.bw : pick.br;
        ta_int   = s_q.busy && s_q.aa && (s_q.cnt == s_q.ws);
        beat_end = s_q.busy && (ta_int || ext_ack);

        if (!s_q.busy) begin
            if (start && hit_any) begin
                s_d.busy = 1'b1;
                s_d.sel  = hit_sel;
                s_d.addr = bus_addr;
                s_d.left = burst_ok ? beats_m1 : '0;
                s_d.cnt  = '0;
                s_d.ws   = pick.ws;
                s_d.aa   = pick.aa;
            end
        end else if (beat_end) begin
            s_d.cnt = '0;
            if (s_q.left == '0) begin
                s_d.busy = 1'b0;
                s_d.sel  = '0;
            end else begin
                s_d.left = s_q.left - 1'b1;
                s_d.addr = s_q.addr + ADDR_W'(STEP);
            end
        end else if (s_q.cnt != '1) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cs_sel  = s_q.sel;
    assign cs_addr = s_q.addr;
    assign busy    = s_q.busy;
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_pkg::*;
#(
    parameter int NUM_CS  = 8,
    parameter int ADDR_W  = 32,
    parameter int TAG_LSB = 16,
    parameter int REG_AW  = 8,
    parameter int BEAT_W  = 2,
    parameter int STEP    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [BEAT_W-1:0] bus_beats_m1,
    input  logic              ext_ack,
    output logic [NUM_CS-1:0] cs_sel,
    output logic [ADDR_W-1:0] cs_addr,
    output logic              ta_int,
    output logic              beat_end,
    output logic              busy
);
    localparam int TAG_W = ADDR_W - TAG_LSB;

    logic [NUM_CS-1:0][TAG_W-1:0] base, mask;
    logic [NUM_CS-1:0]            valid;
    cs_ctl_t [NUM_CS-1:0]         ctl;
    logic [NUM_CS-1:0]            hit_sel;
    logic                         hit_any;

    cs_regs #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_o(base), .mask_o(mask), .valid_o(valid), .ctl_o(ctl)
    );

    cs_match #(.NUM_CS(NUM_CS), .TAG_W(TAG_W)) u_match (
        .addr_tag(bus_addr[ADDR_W-1:TAG_LSB]), .base(base), .mask(mask),
        .valid(valid), .hit_sel(hit_sel), .hit_any(hit_any)
    );

    cs_term #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .STEP(STEP)
    ) u_term (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .hit_sel(hit_sel),
        .hit_any(hit_any), .ctl(ctl), .bus_addr(bus_addr), .bus_write(bus_write),
        .beats_m1(bus_beats_m1), .ext_ack(ext_ack), .cs_sel(cs_sel),
        .cs_addr(cs_addr), .ta_int(ta_int), .beat_end(beat_end), .busy(busy)
    );
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_start,
    input logic              ext_ack,
    input logic [NUM_CS-1:0] cs_sel,
    input logic [ADDR_W-1:0] cs_addr,
    input logic              ta_int,
    input logic              beat_end,
    input logic              busy
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel)); // R5

    AST_SEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(cs_sel) == 1)); // R6

    AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_sel == '0)); // R6

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_end) |=> (busy && $stable(cs_sel))); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_end) |=> $stable(cs_addr)); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_end) |=> (!busy || (cs_addr == $past(cs_addr) + ADDR_W'(STEP)))); // R10

    AST_TA_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ta_int |-> busy); // R7

    AST_EXT_ENDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_ack) |-> beat_end); // R9

    AST_START_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (!busy || $past(bus_start))); // R11
endmodule

bind cs_decoder cs_decoder_chk #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .STEP(STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .ext_ack(ext_ack),
    .cs_sel(cs_sel), .cs_addr(cs_addr), .ta_int(ta_int),
    .beat_end(beat_end), .busy(busy)
);

// File: tb/cs_decoder_test.sv
`timescale 1ns/1ps
module cs_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_start = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_beats_m1 = '0;
    logic        ext_ack = 1'b0;
    logic [7:0]  cs_sel;
    logic [31:0] cs_addr;
    logic        ta_int, beat_end, busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;   // 125 MHz

    cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_beats_m1(bus_beats_m1),
        .ext_ack(ext_ack), .cs_sel(cs_sel), .cs_addr(cs_addr), .ta_int(ta_int),
        .beat_end(beat_end), .busy(busy)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  bm1;
        logic [7:0]  ext_at;
        logic [3:0]  exp_cs;   // 4'hF = nothing selected
        logic [7:0]  exp_cyc;
        logic [3:0]  exp_ta;
        logic [31:0] exp_last;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h1012_3400, 1'b0, 2'd0, 8'hFF, 4'd0, 8'd3,  4'd1, 32'h1012_3400},
        '{32'h1012_3400, 1'b0, 2'd3, 8'hFF, 4'd0, 8'd12, 4'd4, 32'h1012_340C},
        '{32'h1012_3400, 1'b1, 2'd3, 8'hFF, 4'd0, 8'd3,  4'd1, 32'h1012_3400},
        '{32'h1800_0000, 1'b1, 2'd1, 8'hFF, 4'd1, 8'd2,  4'd2, 32'h1800_0004},
        '{32'h2000_0010, 1'b0, 2'd0, 8'd4,  4'd2, 8'd5,  4'd0, 32'h2000_0010},
        '{32'h4000_0000, 1'b0, 2'd0, 8'd1,  4'd4, 8'd2,  4'd0, 32'h4000_0000},
        '{32'h4000_0000, 1'b0, 2'd2, 8'hFF, 4'd4, 8'd16, 4'd1, 32'h4000_0000},
        '{32'h3000_0000, 1'b0, 2'd0, 8'hFF, 4'hF, 8'd0,  4'd0, 32'h0},
        '{32'h5000_0000, 1'b0, 2'd0, 8'hFF, 4'hF, 8'd0,  4'd0, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_access(input logic [31:0] a, input logic wr, input logic [1:0] bm1,
                              input logic [7:0] ext_at, input logic [7:0] inj_at,
                              output int cyc, output int tas, output logic [7:0] sel0,
                              output logic [31:0] last, output int sel_moves,
                              output logic [7:0] sel_after);
        @(negedge clk);
        bus_addr = a; bus_write = wr; bus_beats_m1 = bm1; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        cyc = 0; tas = 0; sel_moves = 0;
        sel0 = cs_sel; last = cs_addr;
        while (busy && cyc < 100) begin
            ext_ack = (cyc == int'(ext_at));
            if (cyc == int'(inj_at)) begin
                bus_start = 1'b1;
                bus_addr  = 32'h1800_0000;
            end
            #1;
            if (ta_int) tas++;
            if (beat_end) last = cs_addr;
            if (cs_sel !== sel0) sel_moves++;
            @(negedge clk);
            ext_ack = 1'b0; bus_start = 1'b0;
            cyc++;
        end
        sel_after = cs_sel;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int cyc, tas, mv;
        logic [7:0] s0, sa;
        logic [31:0] last;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 cs_sel after reset", 32'(cs_sel), 32'h0);
        check("R1 busy after reset", 32'(busy), 32'h0);
        rd_reg(8'h84, d); check("R1 mask ch0 reads 0", d, 32'h0);
        rd_reg(8'h8A, d); check("R1 ctl ch0 reads 0", d, 32'h0);
        run_access(32'h0000_0000, 1'b0, 2'd0, 8'hFF, 8'hFF, cyc, tas, s0, last, mv, sa);
        check("R1 no select when unprogrammed", 32'(s0), 32'h0);
        check("R1 no busy when unprogrammed", 32'(cyc), 32'h0);

        // R2 / R3: register map and readback
        wr_reg(8'h8A, 32'h0000_FFFF);
        rd_reg(8'h8A, d); check("R3 ctl stores only defined fields", d, 32'h0000_3D18);
        wr_reg(8'h8A, 32'h0000_0007);
        rd_reg(8'h8A, d); check("R3 reserved [2:0] read zero", d, 32'h0);
        wr_reg(8'h80, 32'h1000_ABCD);
        wr_reg(8'h84, 32'h00FF_FFFF);
        wr_reg(8'h8A, 32'h0000_0910);
        wr_reg(8'h8C, 32'h1000_0000);
        wr_reg(8'h90, 32'h0FFF_0001);
        wr_reg(8'h96, 32'h0000_0118);
        wr_reg(8'h98, 32'h2000_0000);
        wr_reg(8'h9C, 32'h0000_0001);
        wr_reg(8'hA2, 32'h0000_0000);
        wr_reg(8'hA4, 32'h3000_0000);
        wr_reg(8'hA8, 32'h0000_0000);
        wr_reg(8'hAE, 32'h0000_0100);
        wr_reg(8'hB0, 32'h4000_0000);
        wr_reg(8'hB4, 32'h0000_0001);
        wr_reg(8'hBA, 32'h0000_3D00);
        rd_reg(8'h80, d); check("R2 base ch0 readback", d, 32'h1000_0000);
        rd_reg(8'h84, d); check("R2 mask ch0 readback with valid", d, 32'h00FF_0001);
        rd_reg(8'h96, d); check("R2 ctl ch1 readback", d, 32'h0000_0118);
        rd_reg(8'hB0, d); check("R2 base ch4 readback", d, 32'h4000_0000);
        rd_reg(8'h00, d); check("R2 unmapped offset reads 0", d, 32'h0);
        rd_reg(8'h88, d); check("R2 gap offset reads 0", d, 32'h0);

        // table walk: R4 R5 R6 R7 R8 R9 R10 R11
        for (int v = 0; v < NV; v++) begin
            logic [7:0] exp_sel;
            exp_sel = (VECS[v].exp_cs == 4'hF) ? 8'h00 : (8'h01 << VECS[v].exp_cs);
            run_access(VECS[v].addr, VECS[v].wr, VECS[v].bm1, VECS[v].ext_at, 8'hFF,
                       cyc, tas, s0, last, mv, sa);
            check($sformatf("R4 R5 vec%0d selected channel", v), 32'(s0), 32'(exp_sel));
            check($sformatf("R7 R8 R9 R10 vec%0d busy cycles", v), 32'(cyc), 32'(VECS[v].exp_cyc));
            check($sformatf("R7 R8 vec%0d internal acks", v), 32'(tas), 32'(VECS[v].exp_ta));
            check($sformatf("R6 vec%0d select steady", v), 32'(mv), 32'h0);
            check($sformatf("R6 vec%0d select drops after", v), 32'(sa), 32'h0);
            if (VECS[v].exp_cs != 4'hF)
                check($sformatf("R10 vec%0d final beat address", v), last, VECS[v].exp_last);
        end

        // R11: start during an access is ignored
        run_access(32'h4000_0000, 1'b0, 2'd0, 8'hFF, 8'd3, cyc, tas, s0, last, mv, sa);
        check("R11 start while busy keeps channel", 32'(mv), 32'h0);
        check("R11 start while busy keeps length", 32'(cyc), 32'd16);
        #1;
        check("R11 no new access after end", 32'(busy), 32'h0);

        // R4: invalidating a channel stops it asserting
        wr_reg(8'hB4, 32'h0000_0000);
        run_access(32'h4000_0000, 1'b0, 2'd0, 8'hFF, 8'hFF, cyc, tas, s0, last, mv, sa);
        check("R4 invalid channel never selects", 32'(s0), 32'h0);

        // R8: no auto-ack holds the beat until ext_ack
        run_access(32'h2000_0000, 1'b1, 2'd0, 8'd30, 8'hFF, cyc, tas, s0, last, mv, sa);
        check("R8 waits for external ack", 32'(cyc), 32'd31);
        check("R8 no internal ack", 32'(tas), 32'h0);

        finish_run();
    end
endmodule